// File: doc/BRIEF.md
# Gate Drive Fault Shutdown Guard

This block sits between a three-phase PWM generator and the six gate-drive pins of an inverter. It passes the six logical PWM phases through to the pins. Each phase is translated to the electrical polarity that its gate driver expects. The block also watches two fault sources: an external shutdown pin and an over-current comparator. When either source stays active long enough to count as a real fault, the block drives every pin to its inactive level. It holds that safe state until software issues a clear while both sources are quiet.

Each fault source first passes through a two-flop synchroniser. It then goes through a saturating run-length counter. The source qualifies only after it has been active for a programmable number of consecutive system clocks. This rejects glitches shorter than the programmed width and bounds the delay from a fault edge to the disabled outputs. The shutdown pin has selectable polarity and defaults to active low. The comparator input is active high.

Top module: `gkill_guard`

## Requirements
- R1: A qualified fault from either source drives all six pins to their inactive level and sets `fault_o`.
- R2: `kill_pol` selects the shutdown pin polarity: 0 means the pin is active when low (the default use), and 1 means it is active when high.
- R3: A source qualifies only after it has been active, as seen after synchronisation, for `thr` consecutive clocks. An active run shorter than that leaves the pins and `fault_o` unchanged. A threshold of 0 behaves as 1.
- R4: Counting clock edges after the raw input changes, the pins become inactive on edge `thr`+3 and not earlier. For every threshold up to 97 this is within 100 clocks.
- R5: The fault stays latched. A `flt_clr` pulse clears it only when both synchronised sources are inactive; a clear during an active source is ignored. Normal output resumes on the second edge after an accepted clear.
- R6: `trip_in` is active high and uses its own threshold `trip_thr`, with the same shutdown effect. `fault_src` bit 0 records the shutdown pin and bit 1 records the comparator. Both bits are sticky until an accepted clear.
- R7: `gate_pol` bit i set to 1 makes pin i active low. With no fault, pin i equals `pwm_in[i]` XOR `gate_pol[i]` one clock later. During reset and while faulted, pin i equals `gate_pol[i]`.
- R8: While faulted, changes on `pwm_in` have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 6 | Logical PWM phases, 1 = switch on |
| gate_pol | input | 6 | Per-pin polarity, 1 = active low |
| kill_in | input | 1 | External shutdown pin |
| kill_pol | input | 1 | Shutdown pin polarity, 1 = active high |
| trip_in | input | 1 | Over-current comparator, active high |
| kill_thr | input | 8 | Qualification width for the shutdown pin, in clocks |
| trip_thr | input | 8 | Qualification width for the comparator, in clocks |
| flt_clr | input | 1 | Fault clear strobe |
| gate_out | output | 6 | Pin-level gate drive signals |
| fault_o | output | 1 | Latched fault status |
| fault_src | output | 2 | Sticky fault cause, bit 0 shutdown pin, bit 1 comparator |

## Verification
Pass-through is tried with a table of phase and polarity patterns, including all-zero, all-one and alternating masks. These patterns show that each pin takes its own polarity and that no bits are swapped. Fault detection is tried in several ways:
- A shutdown run one clock short of the threshold, followed by a sustained one. The edge count of the sustained run pins the latency exactly and separates a correct filter from an early or late one.
- A comparator trip and an active-high shutdown with a zero threshold. These show that both sources and both polarity choices reach the latch, and that the cause bits are kept apart.
- A clear issued while the source is still active, then a clear after release. These separate a clear that is properly gated from one that is not.
- Phase and polarity changes while faulted. These show that the safe level follows the polarity input and ignores the phases.

// File: rtl/gk_pkg.sv
package gk_pkg;
    localparam int NGATE    = 6;
    localparam int NSRC     = 2;
    localparam int SRC_KILL = 0;
    localparam int SRC_TRIP = 1;

    typedef struct packed {
        logic            flt;
        logic [NSRC-1:0] src;
    } latch_t;
endpackage

// File: rtl/gk_qualify.sv
module gk_qualify #(
    parameter int CW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_act,
    input  logic [CW-1:0] thr,
    output logic          act,
    output logic          qual
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] eff_thr;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], raw_act};
        if (st_q.sync[SYNC-1]) begin
            if (st_q.cnt != CMAX) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        eff_thr = (thr == '0) ? CW'(1) : thr;
        act     = st_q.sync[SYNC-1];
        qual    = (st_q.cnt >= eff_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a quiet source cannot be qualified on the following cycle
    a_r3_idle_no_qual: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !qual);

    // R3: the run counter saturates and never wraps
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CMAX && act) |=> (st_q.cnt == CMAX));
endmodule

// File: rtl/gk_latch.sv
module gk_latch
    import gk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] qual,
    input  logic [NSRC-1:0] act,
    input  logic            clr,
    output logic            flt,
    output logic [NSRC-1:0] src
);
    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (|qual) begin
            st_d.flt = 1'b1;
            st_d.src = st_q.src | qual;
        end else if (clr && !(|act)) begin
            st_d.flt = 1'b0;
            st_d.src = '0;
        end
        flt = st_q.flt;
        src = st_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: any qualified source sets the latch
    a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual) |=> flt);

    // R5: without a clear the latch holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !clr) |=> flt);

    // R5: a clear while a source is active is refused
    a_r5_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && (|act)) |=> flt);

    // R6: a set latch always names at least one cause
    a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flt |-> (src != '0));
endmodule

// File: rtl/gk_drive.sv
module gk_drive #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kill,
    input  logic [N-1:0] pwm,
    input  logic [N-1:0] pol,
    output logic [N-1:0] pins
);
    typedef struct packed {
        logic [N-1:0] lv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.lv = kill ? '0 : pwm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign pins[g] = st_q.lv[g] ^ pol[g];
    end

    // R1 R8: after a kill cycle every pin sits at its inactive level
    a_r1_off: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (pins == pol));

    // R7: without a kill the pins follow the phases one cycle later
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !kill |=> (pins == ($past(pwm) ^ pol)));
endmodule

// File: rtl/gkill_guard.sv
module gkill_guard
    import gk_pkg::*;
#(
    parameter int THR_W = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NGATE-1:0] pwm_in,
    input  logic [NGATE-1:0] gate_pol,
    input  logic             kill_in,
    input  logic             kill_pol,
    input  logic             trip_in,
    input  logic [THR_W-1:0] kill_thr,
    input  logic [THR_W-1:0] trip_thr,
    input  logic             flt_clr,
    output logic [NGATE-1:0] gate_out,
    output logic             fault_o,
    output logic [NSRC-1:0]  fault_src
);
    logic [NSRC-1:0]  src_raw;
    logic [THR_W-1:0] src_thr [NSRC];
    logic [NSRC-1:0]  src_act;
    logic [NSRC-1:0]  src_qual;
    logic             flt;
    logic             kill_now;

    always_comb begin
        src_raw[SRC_KILL] = kill_pol ? kill_in : ~kill_in;
        src_raw[SRC_TRIP] = trip_in;
        src_thr[SRC_KILL] = kill_thr;
        src_thr[SRC_TRIP] = trip_thr;
        kill_now          = flt | (|src_qual);
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        gk_qualify #(.CW(THR_W), .SYNC(SYNC)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_act (src_raw[s]),
            .thr     (src_thr[s]),
            .act     (src_act[s]),
            .qual    (src_qual[s])
        );
    end

    gk_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (src_qual),
        .act   (src_act),
        .clr   (flt_clr),
        .flt   (flt),
        .src   (fault_src)
    );

    gk_drive #(.N(NGATE)) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .kill  (kill_now),
        .pwm   (pwm_in),
        .pol   (gate_pol),
        .pins  (gate_out)
    );

    assign fault_o = flt;

    // R1: while the latch is set the pins rest at their polarity level
    a_r1_latched_safe: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (gate_out == gate_pol));
endmodule

// File: tb/sim_gkill_guard.sv
module sim_gkill_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] pwm_in, gate_pol;
    logic       kill_in, kill_pol, trip_in, flt_clr;
    logic [7:0] kill_thr, trip_thr;
    logic [5:0] gate_out;
    logic       fault_o;
    logic [1:0] fault_src;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gkill_guard u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .gate_pol(gate_pol),
        .kill_in(kill_in), .kill_pol(kill_pol), .trip_in(trip_in),
        .kill_thr(kill_thr), .trip_thr(trip_thr), .flt_clr(flt_clr),
        .gate_out(gate_out), .fault_o(fault_o), .fault_src(fault_src)
    );

    // {pwm, pol}
    localparam logic [11:0] VEC [8] = '{
        {6'b000000, 6'b000000}, {6'b111111, 6'b000000},
        {6'b000000, 6'b111111}, {6'b111111, 6'b111111},
        {6'b101010, 6'b000000}, {6'b010101, 6'b110000},
        {6'b100001, 6'b011110}, {6'b001100, 6'b101101}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off(output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (gate_out != 6'b000000 && n < 150);
    endtask

    task automatic clear_pulse;
        flt_clr = 1'b1;
        step(1);
        flt_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; pwm_in = 6'b111111; gate_pol = 6'b101010;
        kill_in = 1'b1; kill_pol = 1'b0; trip_in = 1'b0; flt_clr = 1'b0;
        kill_thr = 8'd32; trip_thr = 8'd4;
        step(3);
        check("R7 reset pins", gate_out, 6'b101010);
        check("R1 reset fault", fault_o, 0);
        rst_n = 1'b1;
        step(1);

        foreach (VEC[i]) begin
            pwm_in = VEC[i][11:6]; gate_pol = VEC[i][5:0];
            step(1);
            check("R7 pass-through", gate_out, VEC[i][11:6] ^ VEC[i][5:0]);
        end

        // R3: run one short of threshold is rejected
        pwm_in = 6'b111111; gate_pol = 6'b000000;
        kill_in = 1'b0;
        step(31);
        kill_in = 1'b1;
        step(5);
        check("R3 short pulse fault", fault_o, 0);
        check("R3 short pulse pins", gate_out, 6'b111111);

        // R4 R1 R2: active-low kill held, latency thr+3
        kill_in = 1'b0;
        wait_off(n);
        check("R4 kill latency", n, 35);
        check("R1 fault set", fault_o, 1);
        check("R6 cause kill", fault_src, 2'b01);

        // R8 R7: phases ignored, safe level follows polarity
        pwm_in = 6'b010101;
        step(2);
        check("R8 pwm ignored", gate_out, 6'b000000);
        gate_pol = 6'b110011;
        step(1);
        check("R7 faulted polarity", gate_out, 6'b110011);

        // R5: clear while source active is refused
        clear_pulse();
        step(3);
        check("R5 busy clear", fault_o, 1);

        // R5: clear after release
        kill_in = 1'b1;
        step(4);
        clear_pulse();
        step(2);
        check("R5 cleared", fault_o, 0);
        check("R5 cause cleared", fault_src, 2'b00);
        check("R5 resume", gate_out, 6'b010101 ^ 6'b110011);

        // R6: comparator trip with own threshold
        pwm_in = 6'b111111; gate_pol = 6'b000000;
        step(1);
        trip_in = 1'b1;
        wait_off(n);
        check("R6 trip latency", n, 7);
        check("R6 cause trip", fault_src, 2'b10);
        trip_in = 1'b0;
        step(4);
        clear_pulse();
        step(2);
        check("R6 trip cleared", fault_o, 0);

        // R2: active-high polarity, idle low means no fault
        kill_in = 1'b0; kill_pol = 1'b1; kill_thr = 8'd0;
        step(5);
        check("R2 high-pol idle", fault_o, 0);
        check("R2 high-pol pins", gate_out, 6'b111111);
        kill_in = 1'b1;
        wait_off(n);
        check("R3 zero threshold latency", n, 4);
        check("R2 high-pol fault", fault_src, 2'b01);
        kill_in = 1'b0;
        step(4);
        clear_pulse();
        step(2);
        check("R5 final clear", gate_out, 6'b111111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule